// File: doc/BRIEF.md
# Real-Time Clock Shadowed Time Registers

This block is the timekeeping core of a real-time clock, with a register file that a host reaches through a simple synchronous read/write port. Seven BCD counters run from a once-per-second enable: seconds, minutes, hours, day of week, date, month and two-digit year. They follow month lengths and the leap-year rule for years 00 to 99. The host never reads or writes the running counters directly. It sees a set of user time registers that act as a decoupled shadow of them.

Two control bits link the shadow and the counters. Raising the snapshot bit copies a frozen image of the counters into the user registers, so a multi-byte read is always consistent. Setting the hold bit stops the counters so the host can stage new values. Clearing the hold bit loads the staged values into the counters, and counting resumes.

A control register holds the active-low oscillator enable and the calibration sign and magnitude. The calibration fields are driven out to an external calibration unit. A flags register holds the century flag, the calibration mode enable, the hold bit and the snapshot bit. The century flag is set when the year wraps and is cleared by reading the flags register.

Top module: `rtc_shadow_regs`

## Requirements
- R1: After reset the control register reads 0x80 (oscillator disabled), the flags register reads 0x00, the time registers read 00:00:00 with day of week 01, date 01, month 01 and year 00, and the calibration outputs are 0.
- R2: While the oscillator is enabled and the hold bit is 0, each `tick_1hz` pulse advances the seconds counter by one BCD step.
- R3: The counters roll over as follows: seconds and minutes after 59, hours after 23, day of week 7 to 1, and date after the last day of the month. April, June, September and November have 30 days. February has 29 days when the binary year is divisible by 4 and 28 otherwise. All other months have 31 days. Month wraps from 12 to 01, and year from 99 to 00.
- R4: Writing the flags register with bit 0 (snapshot) = 1 while it was 0 copies all counters into the user time registers. While the bit stays 1, the user registers keep that image as the counters advance.
- R5: While flags bit 1 (hold) is 1, ticks are ignored and the counters do not change.
- R6: Writing the hold bit from 1 to 0 loads all user time registers into the counters.
- R7: Host writes to the time registers (address 2 seconds, 3 minutes, 4 hours, 5 day of week, 6 date, 7 month, 8 year) change only the user registers and never the counters.
- R8: Flags bit 6 (century) is set when the year wraps from 99 to 00 and cleared when the flags register (address 0) is read. When a set and a read fall in the same cycle, the set wins.
- R9: The century bit cannot be written. Flags bits 7 and 5:3 and control bit 6 always read 0, and writes to them are ignored.
- R10: Control bit 7 (address 1) set to 1 halts the time base and ticks are ignored. Set to 0, it lets the time base run.
- R11: Control bit 5 (calibration sign) and bits 4:0 (magnitude) are stored and driven on `cal_sign` and `cal_mag`. Flags bit 2 (calibration mode) is stored and driven on `cal_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up without battery) |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (read side effects) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cal_sign | output | 1 | Stored calibration sign |
| cal_mag | output | 5 | Stored calibration magnitude |
| cal_mode | output | 1 | Calibration mode enable |

## Verification
A table of staged start times, each followed by one tick and a snapshot, drives the counter cascade. The rows run from a plain seconds step up to a carry through every field. They separate 30-day months, 31-day months, and February in leap and common years, including year 00. Directed sequences then tell the three kinds of stopped counting apart: ticks lost to the hold bit, ticks lost to the oscillator disable, and a host write that reached only the shadow. A tick that wraps the year in the same cycle as a flags read separates set-priority from clear-priority on the century flag.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int CALW   = 5;

    localparam logic [AW-1:0] A_FLAGS = 4'd0;
    localparam logic [AW-1:0] A_CTRL  = 4'd1;
    localparam logic [AW-1:0] A_SEC   = 4'd2;
    localparam logic [AW-1:0] A_MIN   = 4'd3;
    localparam logic [AW-1:0] A_HOUR  = 4'd4;
    localparam logic [AW-1:0] A_DOW   = 4'd5;
    localparam logic [AW-1:0] A_DATE  = 4'd6;
    localparam logic [AW-1:0] A_MONTH = 4'd7;
    localparam logic [AW-1:0] A_YEAR  = 4'd8;

    // flags bit positions
    localparam int F_CENT = 6;
    localparam int F_CALM = 2;
    localparam int F_HOLD = 1;
    localparam int F_SNAP = 0;
    // control bit positions
    localparam int C_HALT = 7;
    localparam int C_SIGN = 5;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hour;
        logic [DW-1:0] dow;
        logic [DW-1:0] date;
        logic [DW-1:0] month;
        logic [DW-1:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                      dow: 8'h01, date: 8'h01, month: 8'h01,
                                      year: 8'h00};

    function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_bin(input logic [DW-1:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic [DW-1:0] last_day(input logic [DW-1:0] month,
                                               input logic [DW-1:0] year);
        logic [6:0] yb;
        yb = bcd_bin(year);
        case (month)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_shadow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt,
    output logic      century_wrap
);
    rtc_time_t cnt_d, cnt_q;

    always_comb begin
        cnt_d        = cnt_q;
        century_wrap = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (adv) begin
            if (cnt_q.sec != 8'h59) begin
                cnt_d.sec = bcd_inc(cnt_q.sec);
            end else begin
                cnt_d.sec = 8'h00;
                if (cnt_q.min != 8'h59) begin
                    cnt_d.min = bcd_inc(cnt_q.min);
                end else begin
                    cnt_d.min = 8'h00;
                    if (cnt_q.hour != 8'h23) begin
                        cnt_d.hour = bcd_inc(cnt_q.hour);
                    end else begin
                        cnt_d.hour = 8'h00;
                        cnt_d.dow  = (cnt_q.dow == 8'h07) ? 8'h01 : bcd_inc(cnt_q.dow);
                        if (cnt_q.date != last_day(cnt_q.month, cnt_q.year)) begin
                            cnt_d.date = bcd_inc(cnt_q.date);
                        end else begin
                            cnt_d.date = 8'h01;
                            if (cnt_q.month != 8'h12) begin
                                cnt_d.month = bcd_inc(cnt_q.month);
                            end else begin
                                cnt_d.month = 8'h01;
                                if (cnt_q.year != 8'h99) begin
                                    cnt_d.year = bcd_inc(cnt_q.year);
                                end else begin
                                    cnt_d.year   = 8'h00;
                                    century_wrap = 1'b1;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TIME_RST;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_shadow_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  rtc_time_t       cnt,
    input  logic            century_wrap,
    output logic [DW-1:0]   rdata,
    output rtc_time_t       usr,
    output logic            load,
    output logic            capture,
    output logic            hold,
    output logic            snap,
    output logic            halt,
    output logic            cent,
    output logic            cal_sign,
    output logic [CALW-1:0] cal_mag,
    output logic            cal_mode
);
    typedef struct packed {
        rtc_time_t       usr;
        logic            halt;
        logic            sign;
        logic [CALW-1:0] mag;
        logic            cent;
        logic            calm;
        logic            hold;
        logic            snap;
    } host_st_t;

    host_st_t st_d, st_q;
    logic     flags_wr;

    always_comb begin
        st_d     = st_q;
        flags_wr = wr_en && (addr == A_FLAGS);
        capture  = flags_wr && wdata[F_SNAP] && !st_q.snap;
        load     = flags_wr && !wdata[F_HOLD] && st_q.hold;

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    st_d.halt = wdata[C_HALT];
                    st_d.sign = wdata[C_SIGN];
                    st_d.mag  = wdata[CALW-1:0];
                end
                A_FLAGS: begin
                    st_d.calm = wdata[F_CALM];
                    st_d.hold = wdata[F_HOLD];
                    st_d.snap = wdata[F_SNAP];
                end
                A_SEC:   st_d.usr.sec   = wdata;
                A_MIN:   st_d.usr.min   = wdata;
                A_HOUR:  st_d.usr.hour  = wdata;
                A_DOW:   st_d.usr.dow   = wdata;
                A_DATE:  st_d.usr.date  = wdata;
                A_MONTH: st_d.usr.month = wdata;
                A_YEAR:  st_d.usr.year  = wdata;
                default: ;
            endcase
        end
        if (capture) st_d.usr = cnt;

        if (rd_en && (addr == A_FLAGS)) st_d.cent = 1'b0;
        if (century_wrap)               st_d.cent = 1'b1;

        case (addr)
            A_FLAGS: rdata = {1'b0, st_q.cent, 3'b000, st_q.calm, st_q.hold, st_q.snap};
            A_CTRL:  rdata = {st_q.halt, 1'b0, st_q.sign, st_q.mag};
            A_SEC:   rdata = st_q.usr.sec;
            A_MIN:   rdata = st_q.usr.min;
            A_HOUR:  rdata = st_q.usr.hour;
            A_DOW:   rdata = st_q.usr.dow;
            A_DATE:  rdata = st_q.usr.date;
            A_MONTH: rdata = st_q.usr.month;
            A_YEAR:  rdata = st_q.usr.year;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.usr  <= TIME_RST;
            st_q.halt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign usr      = st_q.usr;
    assign hold     = st_q.hold;
    assign snap     = st_q.snap;
    assign halt     = st_q.halt;
    assign cent     = st_q.cent;
    assign cal_sign = st_q.sign;
    assign cal_mag  = st_q.mag;
    assign cal_mode = st_q.calm;
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_shadow_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_1hz,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            cal_sign,
    output logic [CALW-1:0] cal_mag,
    output logic            cal_mode
);
    rtc_time_t cnt;
    rtc_time_t usr;
    logic      century_wrap;
    logic      load, capture, hold, snap, halt, cent;
    logic      adv;

    assign adv = tick_1hz && !hold && !halt;

    rtc_time_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (adv),
        .load         (load),
        .load_val     (usr),
        .cnt          (cnt),
        .century_wrap (century_wrap)
    );

    rtc_host_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .cnt          (cnt),
        .century_wrap (century_wrap),
        .rdata        (rdata),
        .usr          (usr),
        .load         (load),
        .capture      (capture),
        .hold         (hold),
        .snap         (snap),
        .halt         (halt),
        .cent         (cent),
        .cal_sign     (cal_sign),
        .cal_mag      (cal_mag),
        .cal_mode     (cal_mode)
    );
endmodule

// File: rtl/rtc_shadow_regs_chk.sv
module rtc_shadow_regs_chk
    import rtc_shadow_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input rtc_time_t     cnt,
    input rtc_time_t     usr,
    input logic          load,
    input logic          capture,
    input logic          hold,
    input logic          snap,
    input logic          halt,
    input logic          cent,
    input logic          century_wrap
);
    logic time_wr;
    assign time_wr = wr_en && (addr >= A_SEC) && (addr <= A_YEAR);

    p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt.sec[3:0] <= 4'd9) && (cnt.sec <= 8'h59));

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (usr == $past(cnt)));

    p_image_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && !time_wr) |=> $stable(usr));

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load) |=> $stable(cnt));

    p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(usr)));

    p_century_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        century_wrap |=> cent);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_FLAGS) |-> (rdata[7] == 1'b0 && rdata[5:3] == 3'b000));

    p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(cnt));
endmodule

bind rtc_shadow_regs rtc_shadow_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .rdata        (rdata),
    .cnt          (cnt),
    .usr          (usr),
    .load         (load),
    .capture      (capture),
    .hold         (hold),
    .snap         (snap),
    .halt         (halt),
    .cent         (cent),
    .century_wrap (century_wrap)
);

// File: tb/rtc_shadow_regs_test.sv
module rtc_shadow_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cal_sign;
    logic [4:0] cal_mag;
    logic       cal_mode;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    rtc_shadow_regs uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cal_sign(cal_sign), .cal_mag(cal_mag), .cal_mode(cal_mode)
    );

    // {sec,min,hour,dow,date,month,year}: start value, value after one tick
    localparam int NV = 14;
    localparam logic [55:0] V_START [NV] = '{
        56'h00_00_00_01_01_01_00, 56'h59_00_00_01_01_01_00,
        56'h59_59_23_07_31_01_24, 56'h59_59_23_03_28_02_24,
        56'h59_59_23_03_28_02_23, 56'h59_59_23_02_29_02_00,
        56'h59_59_23_05_30_04_11, 56'h59_59_23_05_30_09_19,
        56'h59_59_23_06_30_11_45, 56'h59_59_23_06_31_12_98,
        56'h59_59_09_01_15_06_50, 56'h59_59_23_01_30_06_16,
        56'h59_59_23_04_29_02_96, 56'h59_59_23_04_30_01_07};
    localparam logic [55:0] V_END [NV] = '{
        56'h01_00_00_01_01_01_00, 56'h00_01_00_01_01_01_00,
        56'h00_00_00_01_01_02_24, 56'h00_00_00_04_29_02_24,
        56'h00_00_00_04_01_03_23, 56'h00_00_00_03_01_03_00,
        56'h00_00_00_06_01_05_11, 56'h00_00_00_06_01_10_19,
        56'h00_00_00_07_01_12_45, 56'h00_00_00_07_01_01_99,
        56'h00_00_10_01_15_06_50, 56'h00_00_00_02_01_07_16,
        56'h00_00_00_05_01_03_96, 56'h00_00_00_05_31_01_07};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic read_time(output logic [55:0] v);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(4'(2 + i), b);
            v[55-8*i -: 8] = b;
        end
    endtask

    task automatic snap_time(output logic [55:0] v);
        wr(4'd0, 8'h01);
        read_time(v);
        wr(4'd0, 8'h00);
    endtask

    task automatic set_time(input logic [55:0] v);
        wr(4'd0, 8'h02);
        for (int i = 0; i < 7; i++) wr(4'(2 + i), v[55-8*i -: 8]);
        wr(4'd0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd1, b); check("R1 ctrl", 64'(b), 64'h80);
        rd(4'd0, b); check("R1 flags", 64'(b), 64'h00);
        read_time(t); check("R1 time", 64'(t), 64'h00_00_00_01_01_01_00);
        check("R1 cal outs", {57'd0, cal_sign, cal_mag, cal_mode}, 64'd0);

        // R10 halted after reset: ticks ignored
        tick(3);
        snap_time(t); check("R10 halted", 64'(t[55:48]), 64'h00);
        wr(4'd1, 8'h00);
        // R2 running: two ticks, two steps
        tick(2);
        snap_time(t); check("R2 advance", 64'(t[55:48]), 64'h02);

        // R5 hold: snapshot taken while holding shows frozen counters
        wr(4'd0, 8'h02);
        tick(3);
        wr(4'd0, 8'h03);
        rd(4'd2, b); check("R5 frozen", 64'(b), 64'h02);
        wr(4'd0, 8'h02);
        wr(4'd0, 8'h00);

        // R7 host write reaches only the shadow
        wr(4'd2, 8'h30);
        rd(4'd2, b); check("R7 shadow written", 64'(b), 64'h30);
        tick(1);
        snap_time(t); check("R7 counter untouched", 64'(t[55:48]), 64'h03);

        // R4 image held while snapshot bit stays 1
        wr(4'd0, 8'h01);
        tick(2);
        rd(4'd2, b); check("R4 image held", 64'(b), 64'h03);
        wr(4'd0, 8'h01);
        rd(4'd2, b); check("R4 no retrigger", 64'(b), 64'h03);
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h01);
        rd(4'd2, b); check("R4 new capture", 64'(b), 64'h05);
        wr(4'd0, 8'h00);

        // R6 commit on hold release
        wr(4'd0, 8'h02);
        wr(4'd3, 8'h42);
        wr(4'd0, 8'h00);
        snap_time(t); check("R6 commit", 64'(t[47:40]), 64'h42);

        // R3 rollover table (also R2, R6)
        for (int i = 0; i < NV; i++) begin
            set_time(V_START[i]);
            tick(1);
            snap_time(t);
            check($sformatf("R3 vector %0d", i), 64'(t), 64'(V_END[i]));
        end

        // R8 century wrap with a flags read in the same cycle
        set_time(56'h59_59_23_04_31_12_99);
        @(negedge clk);
        tick_1hz = 1'b1; addr = 4'd0; rd_en = 1'b1;
        #1 b = rdata;
        @(negedge clk);
        tick_1hz = 1'b0; rd_en = 1'b0;
        check("R8 before wrap", 64'(b), 64'h00);
        rd(4'd0, b); check("R8 set wins", 64'(b), 64'h40);
        rd(4'd0, b); check("R8 cleared by read", 64'(b), 64'h00);
        snap_time(t); check("R8 year wrap", 64'(t), 64'h00_00_00_05_01_01_00);

        // R9 read-only and reserved bits
        wr(4'd0, 8'h40);
        rd(4'd0, b); check("R9 century not writable", 64'(b), 64'h00);
        wr(4'd0, 8'hB8);
        rd(4'd0, b); check("R9 flags reserved", 64'(b), 64'h00);
        wr(4'd1, 8'h7F);
        rd(4'd1, b); check("R9 ctrl reserved", 64'(b), 64'h3F);

        // R11 calibration outputs
        check("R11 cal sign/mag", {58'd0, cal_sign, cal_mag}, 64'h3F);
        wr(4'd0, 8'h04);
        check("R11 cal mode", 64'(cal_mode), 64'd1);
        rd(4'd0, b); check("R11 flags readback", 64'(b), 64'h04);
        wr(4'd0, 8'h00);

        // R10 halt after running
        wr(4'd1, 8'h80);
        tick(2);
        snap_time(t); check("R10 halt stops", 64'(t[55:48]), 64'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule